// File: doc/BRIEF.md
# Go-Back-N Retransmitting Router Output Channel

This block is the transmit half of one router port. Flits coming from the crossbar are written into a small circular store that keeps data bits only. On the way out to the link, the flit at the send position gets an even-parity check bit. Because the check bit is added after the store, no check bits are ever stored.

Each flit that has been sent stays in the store until a fixed round-trip window has passed with no negative acknowledgement. The receiving input channel reports a rejected flit by raising `nack`. The channel then rewinds its send position to the oldest flit not yet acknowledged. It resends that flit and every flit that followed it, in go-back-N fashion.

When retransmission is switched off, the store behaves as a plain FIFO. A slot is freed as soon as its flit leaves. The channel also emits a one-cycle pulse when a packet's tail flit is finally released. This tells the upstream port reservation that it can be dropped.

Top module: `gbn_tx_channel`

## Requirements
- R1: After reset, `in_ready` is 1, `link_valid` is 0 and `rsv_release` is 0.
- R2: `link_code` is the flit's data in its low DATA_W bits, with the even-parity bit of that data in the top bit. `link_tail` carries the flit's tail mark.
- R3: Accepted flits leave in arrival order, at most one per cycle. A flit accepted into an empty channel appears on the link in the cycle after it is accepted.
- R4: `in_ready` is 0 while all four slots hold unsent or unacknowledged flits. Flits offered while it is 0 are dropped. `in_ready` returns in the cycle after the oldest flit is released.
- R5: With retransmission on, a flit sent in cycle c is released at the end of cycle c+4, provided `nack` is not raised in any of cycles c+1 to c+4.
- R6: A `nack` while flits are in flight suppresses sending in that cycle. From the next cycle, the oldest unacknowledged flit is resent, followed by every later flit in order.
- R7: `rsv_release` pulses in the cycle a tail flit is released. A `nack` that covers the tail delays the pulse to four cycles after the tail is resent.
- R8: With `arq_en` = 0, a slot is freed as its flit is sent and `nack` has no effect. `rsv_release` pulses in the cycle the tail flit is sent.
- R9: A `nack` while no flit is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| arq_en | input | 1 | 1 = go-back-N retransmission, 0 = plain FIFO |
| in_valid | input | 1 | Crossbar offers a flit |
| in_ready | output | 1 | Channel can take a flit |
| in_data | input | DATA_W | Flit data bits |
| in_tail | input | 1 | Flit ends a packet |
| link_valid | output | 1 | A coded flit is on the link this cycle |
| link_code | output | DATA_W+1 | Parity bit above the data bits |
| link_tail | output | 1 | Tail mark of the flit on the link |
| nack | input | 1 | Receiver rejected the oldest in-flight flit |
| rsv_release | output | 1 | Pulse when a tail flit is released |

## Verification
The main function is tested with four traffic patterns:

- A lone tail flit with a clean link. This fixes the send cycle, the coding and the release cycle.
- A burst of four flits followed by refused offers. This separates correct release timing from an early or late return of `in_ready`.
- A three-flit packet with a `nack` in the middle of the burst. This distinguishes a true rewind to the oldest flit from a resend of only the rejected one or of none.
- A late `nack` on a lone tail flit. This shows whether the release really waits for the new window.

FIFO mode is run with back-to-back flits and a stray `nack`. This separates immediate slot freeing from the windowed release. A `nack` on an empty channel checks that no replay appears.

// File: rtl/gbn_tx_channel.sv
module gbn_tx_channel #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int RTT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arq_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_tail,
  output logic              link_valid,
  output logic [DATA_W:0]   link_code,
  output logic              link_tail,
  input  logic              nack,
  output logic              rsv_release
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int PW = AW + 1;
  localparam int TW = (RTT > 2) ? $clog2(RTT) : 1;

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [DEPTH-1:0]  tail_q;
  logic [TW-1:0]     tmr_q  [DEPTH];
  logic [PW-1:0]     wr_q, snd_q, ack_q;

  logic [PW-1:0] used;
  logic [AW-1:0] wr_idx, snd_idx, ack_idx;
  logic          has_unsent, inflight, nack_take, push, rel_arq;

  assign used       = wr_q - ack_q;
  assign wr_idx     = wr_q[AW-1:0];
  assign snd_idx    = snd_q[AW-1:0];
  assign ack_idx    = ack_q[AW-1:0];
  assign has_unsent = (snd_q != wr_q);
  assign inflight   = (snd_q != ack_q);
  assign nack_take  = arq_en & nack & inflight;
  assign in_ready   = (used != PW'(DEPTH));
  assign push       = in_valid & in_ready;
  assign rel_arq    = arq_en & inflight & (tmr_q[ack_idx] == '0) & ~nack;

  assign link_valid  = has_unsent & ~nack_take;
  assign link_code   = {^data_q[snd_idx], data_q[snd_idx]};
  assign link_tail   = tail_q[snd_idx];
  assign rsv_release = arq_en ? (rel_arq & tail_q[ack_idx]) : (link_valid & link_tail);

  always_ff @(posedge clk) begin
    if (push) begin
      data_q[wr_idx] <= in_data;
      tail_q[wr_idx] <= in_tail;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      snd_q <= '0;
      ack_q <= '0;
      for (int i = 0; i < DEPTH; i++) tmr_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (tmr_q[i] != '0) tmr_q[i] <= tmr_q[i] - 1'b1;
      if (push) wr_q <= wr_q + 1'b1;
      if (nack_take) begin
        snd_q <= ack_q;
      end else if (link_valid) begin
        snd_q          <= snd_q + 1'b1;
        tmr_q[snd_idx] <= TW'(RTT - 1);
      end
      if (arq_en) begin
        if (rel_arq) ack_q <= ack_q + 1'b1;
      end else if (link_valid) begin
        ack_q <= snd_q + 1'b1;
      end
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    used <= PW'(DEPTH));

  // R1
  reset_ready_chk: assert property (@(posedge clk)
    !rst_n |=> (in_ready && !link_valid));

  // R3
  first_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && used == '0 && !nack) |=> link_valid);

  // R6
  nack_resend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arq_en && nack && inflight) |=> link_valid);

  // R7
  tail_no_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arq_en && rsv_release) |-> !nack);

  // R8
  fifo_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arq_en && link_valid && link_tail) |-> rsv_release);
endmodule

// File: tb/gbn_tx_channel_test.sv
`timescale 1ns/100ps
module gbn_tx_channel_test;
  localparam int DW = 16;

  logic clk = 0, rst_n = 0, arq_en = 1, in_valid = 0, in_tail = 0, nack = 0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, link_valid, link_tail, rsv_release;
  logic [DW:0] link_code;

  int n_chk = 0, n_bad = 0;

  gbn_tx_channel #(.DATA_W(DW), .DEPTH(4), .RTT(4)) uut (
    .clk(clk), .rst_n(rst_n), .arq_en(arq_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_tail(in_tail),
    .link_valid(link_valid), .link_code(link_code), .link_tail(link_tail),
    .nack(nack), .rsv_release(rsv_release));

  always #2.5 clk = ~clk;

  function automatic logic [DW:0] enc(input logic [DW-1:0] d);
    return {^d, d};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input logic v, input logic [DW-1:0] d, input logic t, input logic n);
    @(negedge clk);
    in_valid = v; in_data = d; in_tail = t; nack = n;
    #1;
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 0; arq_en = mode; in_valid = 0; nack = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  task automatic t_reset;
    do_reset(1);
    #1;
    chk("R1 ready", in_ready, 1);
    chk("R1 valid", link_valid, 0);
    chk("R1 release", rsv_release, 0);
  endtask

  task automatic t_single;
    do_reset(1);
    tick(1, 16'h0007, 1, 0);
    tick(0, 0, 0, 0);
    chk("R3 valid c1", link_valid, 1);
    chk("R2 code", link_code, enc(16'h0007));
    chk("R2 tail", link_tail, 1);
    for (int c = 2; c <= 4; c++) begin
      tick(0, 0, 0, 0);
      chk("R5 held", rsv_release, 0);
      chk("R3 single send", link_valid, 0);
    end
    tick(0, 0, 0, 0);
    chk("R7 release c5", rsv_release, 1);
    tick(0, 0, 0, 0);
    chk("R7 one pulse", rsv_release, 0);
  endtask

  task automatic t_full;
    logic [DW-1:0] d [4] = '{16'h1111, 16'h2222, 16'h3333, 16'h8001};
    do_reset(1);
    for (int c = 0; c < 4; c++) begin
      tick(1, d[c], 0, 0);
      chk("R4 ready fill", in_ready, 1);
      if (c > 0) chk("R3 order", link_code, enc(d[c-1]));
    end
    tick(1, 16'hdead, 1, 0);
    chk("R4 full c4", in_ready, 0);
    chk("R3 order last", link_code, enc(d[3]));
    tick(1, 16'hdead, 1, 0);
    chk("R4 full c5", in_ready, 0);
    chk("R4 dropped", link_valid, 0);
    tick(0, 0, 0, 0);
    chk("R4 ready c6", in_ready, 1);
    chk("R4 no extra", link_valid, 0);
  endtask

  task automatic t_nack_burst;
    do_reset(1);
    tick(1, 16'h00a1, 0, 0);
    tick(1, 16'h00b2, 0, 0);
    chk("R3 A", link_code, enc(16'h00a1));
    tick(1, 16'h00c3, 1, 0);
    chk("R3 B", link_code, enc(16'h00b2));
    tick(0, 0, 0, 1);
    chk("R6 quiet", link_valid, 0);
    tick(0, 0, 0, 0);
    chk("R6 resend A", {link_valid, link_code}, {1'b1, enc(16'h00a1)});
    tick(0, 0, 0, 0);
    chk("R6 resend B", {link_valid, link_code}, {1'b1, enc(16'h00b2)});
    tick(0, 0, 0, 0);
    chk("R6 send C", {link_valid, link_code, link_tail}, {1'b1, enc(16'h00c3), 1'b1});
    tick(0, 0, 0, 0);
    chk("R7 no early", rsv_release, 0);
    tick(0, 0, 0, 0);
    tick(0, 0, 0, 0);
    chk("R5 C held", rsv_release, 0);
    tick(0, 0, 0, 0);
    chk("R7 C release", rsv_release, 1);
  endtask

  task automatic t_tail_nack;
    do_reset(1);
    tick(1, 16'h5a5a, 1, 0);
    tick(0, 0, 0, 0);
    chk("R2 code even", link_code, enc(16'h5a5a));
    tick(0, 0, 0, 0);
    tick(0, 0, 0, 0);
    tick(0, 0, 0, 1);
    chk("R7 nack no release", rsv_release, 0);
    tick(0, 0, 0, 0);
    chk("R6 tail resent", link_valid, 1);
    chk("R7 delayed c5", rsv_release, 0);
    for (int c = 6; c <= 8; c++) begin
      tick(0, 0, 0, 0);
      chk("R7 waiting", rsv_release, 0);
    end
    tick(0, 0, 0, 0);
    chk("R7 release c9", rsv_release, 1);
  endtask

  task automatic t_fifo;
    do_reset(0);
    tick(1, 16'h0f0f, 1, 0);
    tick(0, 0, 0, 0);
    chk("R8 send", link_valid, 1);
    chk("R8 release at send", rsv_release, 1);
    tick(0, 0, 0, 1);
    chk("R8 no send", link_valid, 0);
    for (int c = 0; c < 6; c++) begin
      tick(1, DW'(16'h4000 + c), 0, 0);
      chk("R8 ready", in_ready, 1);
      if (c == 0) chk("R8 nack ignored", link_valid, 0);
      else chk("R8 stream", link_code, enc(DW'(16'h4000 + c - 1)));
    end
    tick(0, 0, 0, 0);
    chk("R8 stream end", link_code, enc(16'h4005));
    tick(0, 0, 0, 0);
    chk("R8 drained", link_valid, 0);
  endtask

  task automatic t_idle_nack;
    do_reset(1);
    tick(1, 16'h0033, 0, 1);
    tick(0, 0, 0, 0);
    chk("R9 sent", {link_valid, link_code}, {1'b1, enc(16'h0033)});
    tick(0, 0, 0, 0);
    chk("R9 no replay", link_valid, 0);
    chk("R9 ready", in_ready, 1);
  endtask

  initial begin
    fork
      begin
        t_reset;
        t_single;
        t_full;
        t_nack_burst;
        t_tail_nack;
        t_fifo;
        t_idle_nack;
      end
      begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule